// File: doc/BRIEF.md
# FIFO-Buffered Configuration Port Controller

This block sits between a register-mapped host and a 32-bit configuration port. To configure, the host queues words into a transmit FIFO and issues a write start through the control register. The engine then streams the queued words to the port over a valid/ready handshake. To read back, the host loads a word count into a 12-bit length register and issues a read start. The engine then accepts exactly that many words from the port into a receive FIFO, and the host pops them through a data register.

One done bit in the status register covers both directions. Live free-space and fill-level registers let the host pace its transfers without interrupts. A control bit flushes both FIFOs. Another control bit returns the whole block to its defaults while it is held. Software sets each of these two bits and clears it again with a second write. Four status bits mirror port-side condition inputs.

Register map (byte address on `host_addr`): 0x100 transmit data (write), 0x104 receive data (read-pop), 0x108 length, 0x10C control, 0x110 status, 0x114 transmit free space, 0x118 receive fill level. Any other address reads 0.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the status reads 0x01F OR'd with the mirrored port bits (0x03F with `cp_abort_n` high and the other condition inputs low). At the same point the free space reads 1024, and the fill level, length and control registers read 0.
- R2: Each write to 0x100 queues one word and lowers the free space by one. A write made while the transmit FIFO holds 1024 words is dropped and leaves the queued contents unchanged.
- R3: A control write with bit 0 set, made while idle, starts the transmit drain. Status bit 0 (done) reads 0 until the FIFO is empty and the port has accepted the last word. Words leave in push order. `cp_out_valid` stays low while idle.
- R4: A control write with bit 1 set (and bit 0 clear), made while idle, starts a readback of exactly the length-register count. `cp_in_ready` is low whenever the receive FIFO holds 256 words. Done returns to 1 only after the full count has arrived. A count of 0 leaves done at 1.
- R5: A read of 0x104 pops receive words in arrival order, and 0x118 reports the current count from 0 to 256. A read of 0x104 while that FIFO is empty returns 0 and changes nothing.
- R6: The length register keeps only its low 12 bits, so the largest count is 0xFFF.
- R7: Start bits written while the engine is busy are ignored and do not begin a second transfer.
- R8: Status bits 1 to 4 always read 1. Bits 5, 6, 7 and 8 mirror `cp_abort_n`, `cp_readback_active`, `cp_aligned` and `cp_error`.
- R9: While control bit 2 is set, both FIFOs are held empty: free space reads 1024 and fill level reads 0.
- R10: While control bit 3 is set, the engine returns to idle and the length register and both FIFOs are cleared. This happens even in the middle of a transfer.
- R11: After a drain completes, more words may be queued and a further write start sends only those new words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops receive data at 0x104) |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from the current state |
| cp_out_valid | output | 1 | Word offered to the configuration port |
| cp_out_ready | input | 1 | Port accepts the offered word |
| cp_out_data | output | 32 | Word to the port |
| cp_in_valid | input | 1 | Port offers a readback word |
| cp_in_ready | output | 1 | Engine accepts the readback word |
| cp_in_data | input | 32 | Readback word from the port |
| cp_abort_n | input | 1 | Port abort condition, active low |
| cp_readback_active | input | 1 | Port reports readback in progress |
| cp_aligned | input | 1 | Port reports data alignment |
| cp_error | input | 1 | Port reports a configuration error |

## Verification
The bench fills the transmit FIFO past 1024 words and checks that the overflow words never reach the port. A design that wrapped a pointer or counted dropped writes would emit stale or extra words. It requests a 300-word readback without popping, so the receive FIFO saturates at 256 with `cp_in_ready` low and done still 0. It then pops everything in order; a design that lost the stall or ended the count early would drop words or clear busy too soon. It also tries a read start while a drain is running, a zero-length readback, a pop from an empty FIFO, a flush, and a soft reset in the middle of a readback. A design that honoured the late start, hung on zero, or kept its length after reset is caught there.

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter int WDEPTH = 1024,
  parameter int RDEPTH = 256,
  parameter int DW     = 32,
  parameter int AW     = 12,
  parameter int LEN_W  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          cp_out_valid,
  input  logic          cp_out_ready,
  output logic [DW-1:0] cp_out_data,
  input  logic          cp_in_valid,
  output logic          cp_in_ready,
  input  logic [DW-1:0] cp_in_data,
  input  logic          cp_abort_n,
  input  logic          cp_readback_active,
  input  logic          cp_aligned,
  input  logic          cp_error
);

  localparam int WPW = $clog2(WDEPTH);
  localparam int RPW = $clog2(RDEPTH);
  localparam logic [WPW:0] W_FULL = (WPW+1)'(WDEPTH);
  localparam logic [RPW:0] R_FULL = (RPW+1)'(RDEPTH);
  localparam logic [AW-1:0] A_TXD  = AW'('h100);
  localparam logic [AW-1:0] A_RXD  = AW'('h104);
  localparam logic [AW-1:0] A_LEN  = AW'('h108);
  localparam logic [AW-1:0] A_CTL  = AW'('h10C);
  localparam logic [AW-1:0] A_STS  = AW'('h110);
  localparam logic [AW-1:0] A_FREE = AW'('h114);
  localparam logic [AW-1:0] A_FILL = AW'('h118);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t              st;
  logic [3:0]       ctl;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] remain;

  logic [DW-1:0] tmem [WDEPTH];
  logic [DW-1:0] rmem [RDEPTH];
  logic [WPW-1:0] twp, trp;
  logic [RPW-1:0] rwp, rrp;
  logic [WPW:0]   tcnt;
  logic [RPW:0]   rcnt;

  wire flush  = ctl[2] | ctl[3];
  wire srst   = ctl[3];
  wire idle   = (st == S_IDLE);
  wire ctl_wr = host_wr && host_addr == A_CTL;

  wire t_push = host_wr && host_addr == A_TXD && tcnt != W_FULL && !flush;
  wire t_pop  = cp_out_valid && cp_out_ready;
  wire r_push = cp_in_valid && cp_in_ready;
  wire r_pop  = host_rd && host_addr == A_RXD && rcnt != '0 && !flush;

  assign cp_out_valid = (st == S_TX) && tcnt != '0 && !flush;
  assign cp_out_data  = tmem[trp];
  assign cp_in_ready  = (st == S_RX) && rcnt != R_FULL && !flush;

  always_ff @(posedge clk) begin
    if (t_push) tmem[twp] <= host_wdata;
    if (r_push) rmem[rwp] <= cp_in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else if (flush) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (t_push) twp <= (twp == WPW'(WDEPTH-1)) ? '0 : twp + 1'b1;
      if (t_pop)  trp <= (trp == WPW'(WDEPTH-1)) ? '0 : trp + 1'b1;
      tcnt <= tcnt + (WPW+1)'(t_push) - (WPW+1)'(t_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else if (flush) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (r_push) rwp <= (rwp == RPW'(RDEPTH-1)) ? '0 : rwp + 1'b1;
      if (r_pop)  rrp <= (rrp == RPW'(RDEPTH-1)) ? '0 : rrp + 1'b1;
      rcnt <= rcnt + (RPW+1)'(r_push) - (RPW+1)'(r_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (ctl_wr) ctl <= host_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; len_q <= '0; remain <= '0;
    end else if (srst) begin
      st <= S_IDLE; len_q <= '0; remain <= '0;
    end else begin
      if (host_wr && host_addr == A_LEN) len_q <= host_wdata[LEN_W-1:0];
      case (st)
        S_IDLE:
          if (ctl_wr && !host_wdata[3]) begin
            if (host_wdata[0]) st <= S_TX;
            else if (host_wdata[1] && len_q != '0) begin
              st <= S_RX;
              remain <= len_q;
            end
          end
        S_TX:
          if (tcnt == '0) st <= S_IDLE;
        S_RX:
          if (r_push) begin
            remain <= remain - 1'b1;
            if (remain == LEN_W'(1)) st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_RXD:  host_rdata = (rcnt != '0) ? rmem[rrp] : '0;
      A_LEN:  host_rdata = DW'(len_q);
      A_CTL:  host_rdata = DW'(ctl);
      A_STS:  host_rdata = DW'({cp_error, cp_aligned, cp_readback_active, cp_abort_n, 4'hF, idle});
      A_FREE: host_rdata = DW'(W_FULL - tcnt);
      A_FILL: host_rdata = DW'(rcnt);
      default: host_rdata = '0;
    endcase
  end

  p_tx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= W_FULL);

  p_tx_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == W_FULL && !cp_out_ready && !flush) |=> tcnt == W_FULL);

  p_rx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= R_FULL);

  p_rx_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt == R_FULL |-> !cp_in_ready);

  p_rx_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_push && !srst) |=> remain == $past(remain) - 1'b1);

  p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && ctl_wr && !srst) |=> remain <= $past(remain));

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (st == S_IDLE && len_q == '0 && tcnt == '0 && rcnt == '0));

endmodule

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;
  localparam logic [11:0] A_TXD = 12'h100, A_RXD = 12'h104, A_LEN = 12'h108,
                          A_CTL = 12'h10C, A_STS = 12'h110, A_FREE = 12'h114,
                          A_FILL = 12'h118;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic cp_out_valid, cp_out_ready = 0, cp_in_valid = 0, cp_in_ready;
  logic [31:0] cp_out_data, cp_in_data = '0;
  logic cp_abort_n = 1, cp_readback_active = 0, cp_aligned = 0, cp_error = 0;

  cfg_port_ctrl u_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cp_out_valid(cp_out_valid), .cp_out_ready(cp_out_ready), .cp_out_data(cp_out_data),
    .cp_in_valid(cp_in_valid), .cp_in_ready(cp_in_ready), .cp_in_data(cp_in_data),
    .cp_abort_n(cp_abort_n), .cp_readback_active(cp_readback_active),
    .cp_aligned(cp_aligned), .cp_error(cp_error));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int got_n = 0, sent_n = 0, src_idx = 0;
  bit tx_en = 0, rx_en = 0;
  logic [31:0] got  [0:2047];
  logic [31:0] sent [0:2047];

  function automatic logic [31:0] rb_word(int i);
    return 32'hA5000000 ^ (32'(i) * 32'h9E3779B1);
  endfunction

  function automatic logic [31:0] exp_sts(bit done);
    return {23'b0, cp_error, cp_aligned, cp_readback_active, cp_abort_n, 4'hF, done};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    cp_out_ready = tx_en ? 1'($urandom % 2) : 1'b0;
    cp_in_valid  = rx_en ? ($urandom % 4 != 0) : 1'b0;
    cp_in_data   = rb_word(src_idx);
    #1;
    if (cp_out_valid && cp_out_ready) begin
      if (got_n < 2048) got[got_n] = cp_out_data;
      got_n++;
    end
    if (cp_in_valid && cp_in_ready) src_idx++;
  end

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    #2 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic push_words(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (sent_n - got_n < 1024) begin
        sent[sent_n] = d;
        sent_n++;
      end
      bus_wr(A_TXD, d);
    end
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(A_STS, s);
      if (s[0]) break;
    end
  endtask

  task automatic cmp_drain(string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < sent_n; i++) if (got[i] !== sent[i]) bad++;
    chk({tag, " words sent"}, 32'(got_n), 32'(sent_n));
    chk({tag, " word mismatches"}, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int popped;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    bus_rd(A_STS, v);  chk("R1 status", v, 32'h3F);
    bus_rd(A_FREE, v); chk("R1 free space", v, 32'd1024);
    bus_rd(A_FILL, v); chk("R1 fill level", v, 0);
    bus_rd(A_LEN, v);  chk("R1 length", v, 0);
    bus_rd(A_CTL, v);  chk("R1 control", v, 0);

    // R6 length width
    bus_wr(A_LEN, 32'h0001_FFFF);
    bus_rd(A_LEN, v); chk("R6 length masked", v, 32'hFFF);

    // R2 / R3 queue while idle, then drain
    tx_en = 1;
    push_words(20);
    bus_rd(A_FREE, v); chk("R2 free after 20 pushes", v, 1004);
    chk("R3 no valid while idle", 32'(cp_out_valid), 0);
    chk("R3 nothing sent while idle", 32'(got_n), 0);
    bus_wr(A_LEN, 4);
    rx_en = 1;
    bus_wr(A_CTL, 1);
    bus_rd(A_STS, v); chk("R3 busy after start", 32'(v[0]), 0);
    // R7 read start while draining must be ignored
    bus_wr(A_CTL, 2);
    wait_done();
    repeat (20) @(negedge clk);
    cmp_drain("R3 drain");
    bus_rd(A_FILL, v); chk("R7 late read start ignored", v, 0);
    chk("R7 no readback words taken", 32'(src_idx), 0);
    rx_en = 0;

    // R11 second batch after idle
    push_words(5);
    bus_wr(A_CTL, 1);
    wait_done();
    cmp_drain("R11 second drain");

    // R2 overflow: 1030 pushes while idle, extras dropped
    got_n = 0; sent_n = 0;
    push_words(1030);
    bus_rd(A_FREE, v); chk("R2 free when full", v, 0);
    bus_wr(A_CTL, 1);
    wait_done();
    cmp_drain("R2 overflow drain");
    bus_rd(A_FREE, v); chk("R3 free after drain", v, 1024);
    tx_en = 0;

    // R4 / R5 counted readback with saturation
    src_idx = 0;
    bus_wr(A_LEN, 300);
    rx_en = 1;
    bus_wr(A_CTL, 2);
    for (int i = 0; i < 5000; i++) begin
      bus_rd(A_FILL, v);
      if (v == 256) break;
    end
    chk("R5 fill saturates", v, 256);
    repeat (5) @(negedge clk);
    #2;
    chk("R4 stall when full", 32'(cp_in_ready), 0);
    bus_rd(A_STS, v); chk("R4 busy while pending", 32'(v[0]), 0);
    popped = 0;
    for (int i = 0; i < 5000 && popped < 300; i++) begin
      bus_rd(A_FILL, v);
      if (v != 0) begin
        logic [31:0] w;
        bus_rd(A_RXD, w);
        if (w !== rb_word(popped)) chk("R5 pop order", w, rb_word(popped));
        popped++;
      end
    end
    chk("R4 words received", 32'(popped), 300);
    bus_rd(A_STS, v); chk("R4 done after count", 32'(v[0]), 1);
    chk("R4 port words taken", 32'(src_idx), 300);
    rx_en = 0;

    // R5 empty pop
    bus_rd(A_RXD, v);  chk("R5 empty pop data", v, 0);
    bus_rd(A_FILL, v); chk("R5 fill after empty pop", v, 0);

    // R4 zero length
    bus_wr(A_LEN, 0);
    bus_wr(A_CTL, 2);
    bus_rd(A_STS, v); chk("R4 zero length stays done", 32'(v[0]), 1);

    // R8 status mirror
    cp_abort_n = 0; cp_readback_active = 1; cp_aligned = 0; cp_error = 1;
    bus_rd(A_STS, v); chk("R8 status pattern A", v, exp_sts(1));
    cp_abort_n = 1; cp_readback_active = 0; cp_aligned = 1; cp_error = 0;
    bus_rd(A_STS, v); chk("R8 status pattern B", v, exp_sts(1));
    cp_aligned = 0;

    // R9 flush
    push_words(10);
    src_idx = 0; rx_en = 1;
    bus_wr(A_LEN, 5);
    bus_wr(A_CTL, 2);
    wait_done();
    rx_en = 0;
    bus_rd(A_FILL, v); chk("R9 fill before flush", v, 5);
    bus_wr(A_CTL, 4);
    bus_wr(A_CTL, 0);
    bus_rd(A_FREE, v); chk("R9 free after flush", v, 1024);
    bus_rd(A_FILL, v); chk("R9 fill after flush", v, 0);

    // R10 soft reset mid-readback
    push_words(3);
    bus_wr(A_LEN, 100);
    bus_wr(A_CTL, 2);
    bus_rd(A_STS, v); chk("R10 busy before reset", 32'(v[0]), 0);
    bus_wr(A_CTL, 8);
    bus_wr(A_CTL, 0);
    bus_rd(A_STS, v);  chk("R10 status after reset", v, 32'h3F);
    bus_rd(A_LEN, v);  chk("R10 length cleared", v, 0);
    bus_rd(A_FREE, v); chk("R10 transmit FIFO cleared", v, 1024);
    bus_rd(A_CTL, v);  chk("R10 control cleared", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule